// File: doc/BRIEF.md
# Root Error Status Collector

This block sits at the root port of an advanced error reporting hierarchy. Error messages arrive one per cycle, each with a severity code and the 16-bit ID of the requester that reported it. The block folds each message into a root status register. That register records which error classes have been seen, whether more than one message of a class arrived, and whether the first uncorrectable message was fatal. The block also keeps the source ID of the first correctable and the first uncorrectable reporter.

Software reaches three registers through a simple single-cycle write port and a combinational read port. A command register enables interrupts per class. The status register clears by writing ones. A source register holds the two captured IDs. An interrupt leaves either as a level output or, in message mode, as a one-cycle pulse. The pulse fires only on the edge at which some enabled class first becomes pending.

Top module: `err_root_collector`

## Requirements
- R1: After reset the command register, the status report bits, the source register, `irq_level` and `irq_pulse` are all zero.
- R2: A correctable message (`msg_sev` = 0) sets status bit 0. If bit 0 was already set, it sets bit 1 instead of capturing. Otherwise it stores `msg_src` in source bits 15:0.
- R3: A non-fatal (`msg_sev` = 1) or fatal (`msg_sev` = 2) message sets status bit 2. If bit 2 was already set, it sets bit 3 instead of capturing. Otherwise it stores `msg_src` in source bits 31:16. A non-fatal message also sets bit 5.
- R4: A fatal message sets status bit 6. It sets bit 4 only when bit 2 was clear before the message; otherwise bit 4 keeps its value.
- R5: Writing to the status register (address 1) clears each of bits 6:0 written as one and leaves the bits written as zero unchanged. A message in the same cycle is applied after the clear.
- R6: Status bits 31:27 always read the `irq_num` input, and software writes do not change them.
- R7: In message mode (`msi_mode` = 1), a message pulses `irq_pulse` for one cycle only when the command bit for its class is set and no enabled class was pending before it.
- R8: In message mode, a command write pulses `irq_pulse` only when the enabled-and-pending condition changes from false to true.
- R9: In level mode, a command write sets `irq_level` to the OR over classes of (enable AND received). An enabled message that makes a class pending raises `irq_level`. In message mode `irq_level` is low.
- R10: Severity code 3 is reserved and leaves the status and source registers unchanged.
- R11: Command bits 0, 1 and 2 enable the correctable, non-fatal and fatal classes. The command register is address 0, and its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Error message present this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 reserved |
| msg_src | input | 16 | Requester ID of the reporter |
| msi_mode | input | 1 | 1 selects pulse interrupts, 0 selects level |
| irq_num | input | 5 | Interrupt message number shown in status bits 31:27 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 command, 1 status, 2 source |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_level | output | 1 | Level interrupt |
| irq_pulse | output | 1 | One-cycle message interrupt |

## Verification
The hardest case to reach is a status clear and a message landing in the same cycle. There the message must see the already-cleared register, so it captures a fresh source ID rather than flagging a repeat. The bench reaches this with a dedicated task that drives the write strobe and the message valid on the same edge. Another hard case is a pulse produced by a command write rather than a message. The bench builds that by leaving a fatal class pending while its enable is off, then turning the enable on.

// File: rtl/err_root_collector.sv
module err_root_collector #(
  parameter int SRC_W = 16,
  parameter int NUM_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_valid,
  input  logic [1:0]         msg_sev,
  input  logic [SRC_W-1:0]   msg_src,
  input  logic               msi_mode,
  input  logic [NUM_W-1:0]   irq_num,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_level,
  output logic               irq_pulse
);
  localparam int SRC_TOT = 2 * SRC_W;
  localparam int PAD_W   = 32 - NUM_W - 7;

  logic [2:0]         cmd_q, cmd_d;
  logic [6:0]         st_q, st_clr, st_d;
  logic [SRC_TOT-1:0] src_q, src_d;
  logic               lvl_q, pls_q;

  wire wr_cmd = reg_wr && reg_addr == 2'd0;
  wire wr_st  = reg_wr && reg_addr == 2'd1;
  wire is_cor = msg_valid && msg_sev == 2'd0;
  wire is_nf  = msg_valid && msg_sev == 2'd1;
  wire is_fat = msg_valid && msg_sev == 2'd2;

  assign cmd_d  = wr_cmd ? reg_wdata[2:0] : cmd_q;
  assign st_clr = wr_st ? (st_q & ~reg_wdata[6:0]) : st_q;

  always_comb begin
    st_d  = st_clr;
    src_d = src_q;
    if (is_cor) begin
      if (st_clr[0]) st_d[1] = 1'b1;
      else           src_d[SRC_W-1:0] = msg_src;
      st_d[0] = 1'b1;
    end
    if (is_nf) st_d[5] = 1'b1;
    if (is_fat) begin
      if (!st_clr[2]) st_d[4] = 1'b1;
      st_d[6] = 1'b1;
    end
    if (is_nf || is_fat) begin
      if (st_clr[2]) st_d[3] = 1'b1;
      else           src_d[SRC_TOT-1:SRC_W] = msg_src;
      st_d[2] = 1'b1;
    end
  end

  wire pend_pre  = |(cmd_q & {st_clr[6], st_clr[5], st_clr[0]});
  wire pend_post = |(cmd_d & {st_d[6], st_d[5], st_d[0]});
  wire rise      = (msg_valid || wr_cmd) && !pend_pre && pend_post;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      st_q  <= '0;
      src_q <= '0;
      lvl_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      st_q  <= st_d;
      src_q <= src_d;
      pls_q <= msi_mode && rise;
      if (msi_mode)    lvl_q <= 1'b0;
      else if (wr_cmd) lvl_q <= pend_post;
      else if (rise)   lvl_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {29'd0, cmd_q};
      2'd1:    reg_rdata = {irq_num, {PAD_W{1'b0}}, st_q};
      2'd2:    reg_rdata = src_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_level = lvl_q;
  assign irq_pulse = pls_q;
endmodule

// File: rtl/err_root_collector_chk.sv
module err_root_collector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        msg_valid,
  input logic [1:0]  msg_sev,
  input logic        msi_mode,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [6:0]  st_q,
  input logic [31:0] src_q,
  input logic        irq_level,
  input logic        irq_pulse
);
  wire clr_wr = reg_wr && reg_addr == 2'd1;

  // R2
  cor_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_sev == 2'd0 |=> st_q[0]);

  // R2
  cor_src_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[0] && !(clr_wr && reg_wdata[0]) |=> $stable(src_q[15:0]));

  // R4
  first_fatal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_sev == 2'd2 && st_q[2] && !(clr_wr && (reg_wdata[2] || reg_wdata[4]))
    |=> st_q[4] == $past(st_q[4]));

  // R5
  w1c_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && reg_wdata[1] && !(msg_valid && msg_sev == 2'd0) |=> !st_q[1]);

  // R10
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_sev == 2'd3 && !reg_wr |=> $stable(st_q) && $stable(src_q));

  // R7
  pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(msi_mode));

  // R9
  level_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_mode |=> !irq_level);
endmodule

bind err_root_collector err_root_collector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
  .msi_mode(msi_mode), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .st_q(st_q), .src_q(src_q),
  .irq_level(irq_level), .irq_pulse(irq_pulse)
);

// File: tb/err_root_collector_bench.sv
module err_root_collector_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_valid = 1'b0;
  logic [1:0] msg_sev = '0;
  logic [15:0] msg_src = '0;
  logic msi_mode = 1'b0;
  logic [4:0] irq_num = 5'h13;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_level, irq_pulse;
  int n_chk = 0, n_bad = 0;
  localparam logic [31:0] NUMF = 32'h9800_0000;

  always #2 clk = ~clk;

  err_root_collector u_err_root_collector (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
    .msg_src(msg_src), .msi_mode(msi_mode), .irq_num(irq_num),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_level(irq_level), .irq_pulse(irq_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic step(input bit wr, input logic [1:0] a, input logic [31:0] wd,
                      input bit mv, input logic [1:0] sv, input logic [15:0] src);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    msg_valid = mv; msg_sev = sv; msg_src = src;
    @(negedge clk);
    reg_wr = 1'b0; msg_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0, 2'd0, 16'h0);
  endtask

  task automatic msg(input logic [1:0] sv, input logic [15:0] src);
    step(1'b0, 2'd0, 32'h0, 1'b1, sv, src);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); check("R1 cmd", d, 0);
    rd(2'd1, d); check("R1 status", d, NUMF);
    rd(2'd2, d); check("R1 src", d, 0);
    check("R1 level", irq_level, 0);
    check("R1 pulse", irq_pulse, 0);
  endtask

  task automatic t_cor;
    logic [31:0] d;
    msg(2'd0, 16'h1111);
    rd(2'd1, d); check("R2 first cor status", d, NUMF | 32'h01);
    rd(2'd2, d); check("R2 first cor src", d, 32'h0000_1111);
    msg(2'd0, 16'h2222);
    rd(2'd1, d); check("R2 multi cor status", d, NUMF | 32'h03);
    rd(2'd2, d); check("R2 src kept", d, 32'h0000_1111);
  endtask

  task automatic t_uncor;
    logic [31:0] d;
    msg(2'd1, 16'hAAAA);
    rd(2'd1, d); check("R3 nonfatal status", d, NUMF | 32'h27);
    rd(2'd2, d); check("R3 uncor src", d, 32'hAAAA_1111);
    msg(2'd2, 16'hBBBB);
    rd(2'd1, d); check("R4 fatal after uncor", d, NUMF | 32'h6F);
    rd(2'd2, d); check("R3 uncor src kept", d, 32'hAAAA_1111);
    wr_reg(2'd1, 32'h7F);
    rd(2'd1, d); check("R5 clear all", d, NUMF);
    msg(2'd2, 16'hCCCC);
    rd(2'd1, d); check("R4 first fatal", d, NUMF | 32'h54);
    rd(2'd2, d); check("R3 fatal src", d, 32'hCCCC_1111);
    wr_reg(2'd1, 32'h7F);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    msg(2'd0, 16'h1234);
    wr_reg(2'd1, 32'h0);
    rd(2'd1, d); check("R5 zero write no effect", d, NUMF | 32'h01);
    step(1'b1, 2'd1, 32'h01, 1'b1, 2'd0, 16'h3333);
    rd(2'd1, d); check("R5 clear then msg status", d, NUMF | 32'h01);
    rd(2'd2, d); check("R5 clear then msg src", d, 32'hCCCC_3333);
    wr_reg(2'd1, 32'hF800_0000);
    rd(2'd1, d); check("R6 number field read-only", d, NUMF | 32'h01);
    irq_num = 5'h05;
    rd(2'd1, d); check("R6 number follows input", d, 32'h2800_0001);
    irq_num = 5'h13;
    wr_reg(2'd1, 32'h7F);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    msg(2'd3, 16'h5555);
    rd(2'd1, d); check("R10 status unchanged", d, NUMF);
    rd(2'd2, d); check("R10 src unchanged", d, 32'hCCCC_3333);
  endtask

  task automatic t_cmd;
    logic [31:0] d;
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R11 cmd bits", d, 32'h7);
    wr_reg(2'd0, 32'h0);
    rd(2'd0, d); check("R11 cmd cleared", d, 32'h0);
  endtask

  task automatic t_msi;
    msi_mode = 1'b1;
    wr_reg(2'd0, 32'h7);
    check("R8 enable with nothing pending", irq_pulse, 0);
    msg(2'd0, 16'h0001);
    check("R7 pulse on first enabled msg", irq_pulse, 1);
    @(negedge clk);
    check("R7 pulse one cycle", irq_pulse, 0);
    msg(2'd1, 16'h0002);
    check("R7 no pulse when already pending", irq_pulse, 0);
    check("R9 level low in msg mode", irq_level, 0);
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd1, 32'h7F);
    msg(2'd2, 16'h0003);
    check("R7 no pulse when disabled", irq_pulse, 0);
    wr_reg(2'd0, 32'h4);
    check("R8 pulse on enable of pending", irq_pulse, 1);
    wr_reg(2'd0, 32'h6);
    check("R8 no pulse when already true", irq_pulse, 0);
  endtask

  task automatic t_level;
    msi_mode = 1'b0;
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd1, 32'h7F);
    check("R9 level low", irq_level, 0);
    msg(2'd0, 16'h0004);
    check("R9 disabled msg no level", irq_level, 0);
    check("R7 no pulse in level mode", irq_pulse, 0);
    wr_reg(2'd0, 32'h1);
    check("R9 level follows cmd write", irq_level, 1);
    wr_reg(2'd0, 32'h2);
    check("R9 level drops on cmd write", irq_level, 0);
    msg(2'd1, 16'h0005);
    check("R9 enabled msg raises level", irq_level, 1);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cor();
        t_uncor();
        t_w1c();
        t_reserved();
        t_cmd();
        t_msi();
        t_level();
      end
      begin
        repeat (20000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule